// File: doc/BRIEF.md
# TDM Time-Slot Routing Engine

The engine sits between a serial TDM port and five internal serial channels. It cuts each frame into 8-bit time slots, counted from the frame start strobe supplied by the port timing logic. It decides for every slot which channel owns it, or whether the slot is left unused. Ownership comes from a route table of run-length entries. Each entry gives a slot count and a destination code. The entries are walked in order from slot 0 of the frame, so consecutive entries cover consecutive slots. Transmit and receive each have their own table and their own walker.

On receive, the engine collects the eight bits of a slot, most significant bit first. It then presents the byte for one cycle with the owning channel code as a tag. On transmit, at the first bit of each owned slot, it takes one byte from the owning channel through a ready/acknowledge pair and shifts it out. Unused slots, and owned slots whose channel has nothing ready, carry all-ones filler. The second case also sets a sticky underrun flag for that channel.

Each walker is a three-state machine. IDLE is entered at a frame start taken while `enable` is low, and nothing is routed there. RUN is entered at a frame start taken while `enable` is high; entry 0 is loaded and the walker steps through the entries. PAST is entered from RUN when the last entry's count runs out, and every later slot is unused. The transitions are START_RUN (any state to RUN at frame start with enable), START_IDLE (any state to IDLE at frame start without enable), NEXT_ENTRY (RUN to RUN when a count is spent and entries remain) and END_TABLE (RUN to PAST). The table is software-written only while the engine is disabled and idle.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset `tx_bit_out` is 1, `rx_vld` is 0, `tx_ack` is 0 and `underrun` is 0.
- R2: A bit strobe (`bit_en`) with `frame_sync` high carries bit 7 of slot 0. Slots are 8 strobes long and bits run MSB first. The transmit bit for a strobe appears on `tx_bit_out` after that strobe's clock edge.
- R3: Table entries map consecutive slots in order. Entry i covers its count (1 to 64) of slots after those covered by entries 0..i-1. Destination code 0 means unused, codes 1..5 select channel index code-1, and codes 6 and 7 are treated as unused.
- R4: For each received slot owned by code 1..5, `rx_vld` pulses for one cycle right after the strobe that samples the slot's last bit. `rx_byte` then holds the 8 sampled bits (first bit as MSB) and `rx_chan` holds the code. Unused slots give no pulse.
- R5: On the strobe that starts a transmit slot owned by code c (1..5) with `tx_rdy[c-1]` high, `tx_ack` is one-hot at bit c-1 in that same cycle. The slot then carries `tx_data[8*(c-1) +: 8]`. Unused slots carry 8'hFF.
- R6: When the owning channel's `tx_rdy` is low at slot start, the slot carries 8'hFF, there is no acknowledge, and `underrun[c-1]` is set and stays set until reset.
- R7: Slots beyond the last entry (entry count is `cfg_len`) are unused until the next frame start, which rewinds to entry 0.
- R8: The transmit table (`cfg_dir`=0) and the receive table (`cfg_dir`=1) are independent.
- R9: `enable` is sampled only at frame start. A change in mid-frame leaves the rest of that frame as it was. A frame started while disabled routes nothing: no `rx_vld`, no `tx_ack`, all ones on transmit.
- R10: Entry and length writes are ignored while `enable` is high or the last frame start was taken while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Routing enable, sampled at frame start |
| bit_en | input | 1 | One strobe per serial bit |
| frame_sync | input | 1 | Marks the strobe carrying the first bit of slot 0 |
| rx_bit_in | input | 1 | Received serial bit |
| tx_bit_out | output | 1 | Transmitted serial bit |
| cfg_we_ent | input | 1 | Write one route entry |
| cfg_we_len | input | 1 | Write the entry count |
| cfg_dir | input | 1 | 0 transmit table, 1 receive table |
| cfg_idx | input | 6 | Entry index |
| cfg_cnt | input | 7 | Slot count 1..64 |
| cfg_dst | input | 3 | Destination code |
| cfg_len | input | 7 | Number of entries 1..64 |
| rx_vld | output | 1 | Received slot byte valid |
| rx_byte | output | 8 | Received slot byte |
| rx_chan | output | 3 | Destination code of the received byte |
| tx_rdy | input | 5 | Per channel: transmit byte available |
| tx_data | input | 40 | Per channel transmit byte, channel i at bits 8i+7..8i |
| tx_ack | output | 5 | Per channel: byte taken this cycle |
| underrun | output | 5 | Sticky per-channel transmit underrun |

## Verification
The hardest states to reach are the two edges of a walker's life: a 64-slot entry whose count runs to zero exactly at the end of the table, and the slots after that point. The bench loads a single-entry table of count 64 and drives a 66-slot frame, so the END_TABLE transition is followed by unused slots. Two later frames of different lengths check that a fresh frame start rewinds the walker. A second hard case is a register write that should be dropped. The bench issues writes while routing is live and checks the following frame against the old table. It also toggles `enable` in mid-frame in both directions to show that only the frame start samples it.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int SLOT_W = 8;
    localparam int NUM_CH = 5;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_RUN  = 2'd1,
        W_PAST = 2'd2
    } walk_state_t;

    function automatic logic is_chan(input logic [CODE_W-1:0] code);
        return (code >= 3'd1) && (code <= 3'(NUM_CH));
    endfunction
endpackage

// File: rtl/tsr_table.sv
module tsr_table #(
    parameter int DEPTH = 64,
    parameter int IW    = 6,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_ent,
    input  logic          we_len,
    input  logic [IW-1:0] w_idx,
    input  logic [CW-1:0] w_cm1,
    input  logic [2:0]    w_dst,
    input  logic [IW:0]   w_len,
    input  logic [IW-1:0] r_idx,
    output logic [CW-1:0] r_cm1,
    output logic [2:0]    r_dst,
    output logic [IW:0]   len_q
);
    localparam int EW = CW + 3;

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            len_q <= (IW+1)'(1);
        end else begin
            if (we_ent) mem[w_idx] <= {w_cm1, w_dst};
            if (we_len) len_q <= w_len;
        end
    end

    assign r_cm1 = mem[r_idx][EW-1:3];
    assign r_dst = mem[r_idx][2:0];
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker
    import tsr_pkg::*;
#(
    parameter int IW = 6,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_start,
    input  logic          frame_start,
    input  logic          enable,
    input  logic [IW:0]   len,
    input  logic [CW-1:0] ent_cm1,
    input  logic [2:0]    ent_dst,
    output logic [IW-1:0] rd_idx,
    output logic [2:0]    dst_nxt,
    output logic [2:0]    dst_q,
    output logic          busy
);
    walk_state_t   st, st_n;
    logic [IW-1:0] idx, idx_n;
    logic [CW-1:0] rem, rem_n;
    logic [2:0]    dst, dst_n;
    logic [IW:0]   idx_inc;

    assign idx_inc = {1'b0, idx} + {{IW{1'b0}}, 1'b1};
    assign rd_idx  = frame_start ? '0 : idx_inc[IW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= W_IDLE;
            idx <= '0;
            rem <= '0;
            dst <= '0;
        end else begin
            st  <= st_n;
            idx <= idx_n;
            rem <= rem_n;
            dst <= dst_n;
        end
    end

    always_comb begin
        st_n  = st;
        idx_n = idx;
        rem_n = rem;
        dst_n = dst;
        if (frame_start) begin
            if (enable) begin
                st_n  = W_RUN;
                idx_n = '0;
                rem_n = ent_cm1;
                dst_n = ent_dst;
            end else begin
                st_n  = W_IDLE;
                dst_n = '0;
            end
        end else if (slot_start) begin
            unique case (st)
                W_RUN: begin
                    if (rem != '0) begin
                        rem_n = rem - 1'b1;
                    end else if (idx_inc >= len) begin
                        st_n  = W_PAST;
                        dst_n = '0;
                    end else begin
                        idx_n = idx_inc[IW-1:0];
                        rem_n = ent_cm1;
                        dst_n = ent_dst;
                    end
                end
                W_IDLE, W_PAST: begin
                    dst_n = '0;
                end
                default: begin
                    st_n  = W_IDLE;
                    dst_n = '0;
                end
            endcase
        end
    end

    always_comb begin
        dst_nxt = dst_n;
        dst_q   = dst;
        busy    = (st != W_IDLE);
    end
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
    import tsr_pkg::*;
#(
    parameter int MAX_ENT = 64,
    parameter int MAX_CNT = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    bit_en,
    input  logic                    frame_sync,
    input  logic                    rx_bit_in,
    output logic                    tx_bit_out,
    input  logic                    cfg_we_ent,
    input  logic                    cfg_we_len,
    input  logic                    cfg_dir,
    input  logic [$clog2(MAX_ENT)-1:0] cfg_idx,
    input  logic [$clog2(MAX_CNT):0]   cfg_cnt,
    input  logic [CODE_W-1:0]       cfg_dst,
    input  logic [$clog2(MAX_ENT):0]   cfg_len,
    output logic                    rx_vld,
    output logic [SLOT_W-1:0]       rx_byte,
    output logic [CODE_W-1:0]       rx_chan,
    input  logic [NUM_CH-1:0]       tx_rdy,
    input  logic [NUM_CH*SLOT_W-1:0] tx_data,
    output logic [NUM_CH-1:0]       tx_ack,
    output logic [NUM_CH-1:0]       underrun
);
    localparam int IW = $clog2(MAX_ENT);
    localparam int CW = $clog2(MAX_CNT);
    localparam int PW = $clog2(SLOT_W);
    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;

    logic [PW-1:0]     bcnt;
    logic [PW-1:0]     pos;
    logic              slot_start, frame_start, wr_ok;
    logic [2:0]        dst_nxt [2];
    logic [2:0]        dst_q   [2];
    logic [1:0]        busy;
    logic [SLOT_W-1:0] tx_sh, rx_sh, tx_load;
    logic [NUM_CH-1:0] owner, ur_q;

    assign pos         = frame_sync ? '0 : bcnt;
    assign slot_start  = bit_en && (pos == '0);
    assign frame_start = bit_en && frame_sync;
    assign wr_ok       = !enable && (busy == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bcnt <= '0;
        else if (bit_en) bcnt <= pos + 1'b1;
    end

    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic [IW-1:0] rd_idx;
        logic [CW-1:0] ent_cm1;
        logic [2:0]    ent_dst;
        logic [IW:0]   len_q;
        logic          sel;

        assign sel = (cfg_dir == d[0]) && wr_ok;

        tsr_table #(.DEPTH(MAX_ENT), .IW(IW), .CW(CW)) u_tab (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_ent (cfg_we_ent && sel),
            .we_len (cfg_we_len && sel),
            .w_idx  (cfg_idx),
            .w_cm1  (cfg_cnt[CW-1:0] - 1'b1),
            .w_dst  (cfg_dst),
            .w_len  (cfg_len),
            .r_idx  (rd_idx),
            .r_cm1  (ent_cm1),
            .r_dst  (ent_dst),
            .len_q  (len_q)
        );

        tsr_walker #(.IW(IW), .CW(CW)) u_walk (
            .clk         (clk),
            .rst_n       (rst_n),
            .slot_start  (slot_start),
            .frame_start (frame_start),
            .enable      (enable),
            .len         (len_q),
            .ent_cm1     (ent_cm1),
            .ent_dst     (ent_dst),
            .rd_idx      (rd_idx),
            .dst_nxt     (dst_nxt[d]),
            .dst_q       (dst_q[d]),
            .busy        (busy[d])
        );
    end

    // Transmit: owner decode, byte select, acknowledge and underrun.
    always_comb begin
        owner   = '0;
        tx_load = '1;
        for (int c = 0; c < NUM_CH; c++) begin
            if (dst_nxt[DIR_TX] == 3'(c + 1)) begin
                owner[c] = 1'b1;
                if (tx_rdy[c]) tx_load = tx_data[c*SLOT_W +: SLOT_W];
            end
        end
        tx_ack = slot_start ? (owner & tx_rdy) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '1;
            ur_q  <= '0;
        end else if (bit_en) begin
            if (slot_start) begin
                tx_sh <= tx_load;
                ur_q  <= ur_q | (owner & ~tx_rdy);
            end else begin
                tx_sh <= {tx_sh[SLOT_W-2:0], 1'b1};
            end
        end
    end

    assign tx_bit_out = tx_sh[SLOT_W-1];
    assign underrun   = ur_q;

    // Receive: deserialize and tag with the owning code.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            rx_vld  <= 1'b0;
            rx_byte <= '0;
            rx_chan <= '0;
        end else begin
            rx_vld <= 1'b0;
            if (bit_en) begin
                rx_sh <= {rx_sh[SLOT_W-2:0], rx_bit_in};
                if ((pos == PW'(SLOT_W - 1)) && is_chan(dst_q[DIR_RX])) begin
                    rx_vld  <= 1'b1;
                    rx_byte <= {rx_sh[SLOT_W-2:0], rx_bit_in};
                    rx_chan <= dst_q[DIR_RX];
                end
            end
        end
    end
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
    parameter int NCH = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bit_en,
    input logic           rx_vld,
    input logic [2:0]     rx_chan,
    input logic [NCH-1:0] tx_ack,
    input logic [NCH-1:0] underrun
);
    p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_ack));

    p_ack_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack != '0) |-> bit_en);

    p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((underrun & $past(underrun)) == $past(underrun)));

    p_rx_chan_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> ((rx_chan >= 3'd1) && (rx_chan <= 3'(NCH))));

    p_rx_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> !rx_vld);
endmodule

bind tdm_slot_router tsr_checker #(.NCH(tsr_pkg::NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .rx_vld   (rx_vld),
    .rx_chan  (rx_chan),
    .tx_ack   (tx_ack),
    .underrun (underrun)
);

// File: tb/tdm_slot_router_tb.sv
module tdm_slot_router_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, bit_en = 1'b0, frame_sync = 1'b0, rx_bit_in = 1'b0;
    logic        tx_bit_out;
    logic        cfg_we_ent = 1'b0, cfg_we_len = 1'b0, cfg_dir = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [6:0]  cfg_cnt = '0;
    logic [2:0]  cfg_dst = '0;
    logic [6:0]  cfg_len = '0;
    logic        rx_vld;
    logic [7:0]  rx_byte;
    logic [2:0]  rx_chan;
    logic [4:0]  tx_rdy = '1;
    logic [39:0] tx_data;
    logic [4:0]  tx_ack, underrun;

    int total = 0, bad = 0;
    int tcnt [2][64];
    int tdst [2][64];
    int tlen [2];
    int pops [5];
    int fr = 0;
    bit live = 1'b0;
    logic [4:0] exp_ur = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int c = 0; c < 5; c++) tx_data[c*8 +: 8] = 8'(c*40 + pops[c]*3 + 1);

    tdm_slot_router u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_en(bit_en),
        .frame_sync(frame_sync), .rx_bit_in(rx_bit_in), .tx_bit_out(tx_bit_out),
        .cfg_we_ent(cfg_we_ent), .cfg_we_len(cfg_we_len), .cfg_dir(cfg_dir),
        .cfg_idx(cfg_idx), .cfg_cnt(cfg_cnt), .cfg_dst(cfg_dst), .cfg_len(cfg_len),
        .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_chan(rx_chan),
        .tx_rdy(tx_rdy), .tx_data(tx_data), .tx_ack(tx_ack), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s frame=%0d actual=%0h expected=%0h", req, fr, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic int dst_of(input int d, input int s);
        int base = 0;
        for (int i = 0; i < tlen[d]; i++) begin
            if (s < base + tcnt[d][i]) return (tdst[d][i] <= 5) ? tdst[d][i] : 0;
            base += tcnt[d][i];
        end
        return 0;
    endfunction

    task automatic cfg_ent(input int d, input int i, input int n, input int ds);
        cfg_dir = d[0]; cfg_idx = 6'(i); cfg_cnt = 7'(n); cfg_dst = 3'(ds);
        cfg_we_ent = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_we_ent = 1'b0;
        if (!enable && !live) begin tcnt[d][i] = n; tdst[d][i] = ds; end
    endtask

    task automatic cfg_n(input int d, input int n);
        cfg_dir = d[0]; cfg_len = 7'(n); cfg_we_len = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_we_len = 1'b0;
        if (!enable && !live) tlen[d] = n;
    endtask

    task automatic run_frame(input int ns, input int flip_s, input bit flip_v, input string tag);
        logic [7:0] eb, gb, rb;
        logic [4:0] ea;
        int td, rd;
        ea = '0; eb = '1; gb = '0; td = 0;
        for (int s = 0; s < ns; s++) begin
            for (int p = 0; p < 8; p++) begin
                if (s == flip_s && p == 0) enable = flip_v;
                if (s == 0 && p == 0) live = enable;
                rb = 8'(s*37 + fr*11 + 5);
                frame_sync = (s == 0 && p == 0);
                bit_en = 1'b1;
                rx_bit_in = rb[7-p];
                if (p == 0) begin
                    td = live ? dst_of(0, s) : 0;
                    ea = '0; eb = '1;
                    if (td > 0) begin
                        if (tx_rdy[td-1]) begin
                            ea = 5'(1 << (td-1));
                            eb = 8'((td-1)*40 + pops[td-1]*3 + 1);
                        end else begin
                            exp_ur[td-1] = 1'b1;
                        end
                    end
                    #1;
                    chk(tx_ack == ea, {tag, " R5 ack"}, int'(tx_ack), int'(ea));
                end
                @(posedge clk); @(negedge clk);
                if (p == 0 && ea != '0) pops[td-1]++;
                gb[7-p] = tx_bit_out;
                rd = live ? dst_of(1, s) : 0;
                if (p == 7) begin
                    chk(gb == eb, {tag, (td == 0) ? " R3 unused tx" : (ea != 0) ? " R5 tx byte" : " R6 filler"},
                        int'(gb), int'(eb));
                    chk(rx_vld == (rd != 0), {tag, " R4 rx strobe"}, int'(rx_vld), int'(rd != 0));
                    if (rd != 0 && rx_vld) begin
                        chk(rx_byte == rb, {tag, " R4 rx byte"}, int'(rx_byte), int'(rb));
                        chk(int'(rx_chan) == rd, {tag, " R4 rx tag"}, int'(rx_chan), rd);
                    end
                end else if (rx_vld) begin
                    chk(1'b0, {tag, " R2 strobe mid-slot"}, 1, 0);
                end
            end
        end
        bit_en = 1'b0; frame_sync = 1'b0;
        chk(underrun == exp_ur, {tag, " R6 underrun flags"}, int'(underrun), int'(exp_ur));
        fr++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog R1", 0, 1);
        finish_run();
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            tlen[d] = 1;
            for (int i = 0; i < 64; i++) begin tcnt[d][i] = 1; tdst[d][i] = 0; end
        end
        for (int c = 0; c < 5; c++) pops[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_bit_out == 1'b1, "R1 tx idle", int'(tx_bit_out), 1);
        chk(rx_vld == 1'b0, "R1 rx_vld", int'(rx_vld), 0);
        chk(tx_ack == '0, "R1 tx_ack", int'(tx_ack), 0);
        chk(underrun == '0, "R1 underrun", int'(underrun), 0);

        cfg_ent(0, 0, 2, 0); cfg_ent(0, 1, 3, 1); cfg_ent(0, 2, 1, 0);
        cfg_ent(0, 3, 2, 5); cfg_ent(0, 4, 4, 3); cfg_n(0, 5);
        cfg_ent(1, 0, 1, 4); cfg_ent(1, 1, 2, 0); cfg_ent(1, 2, 3, 2);
        cfg_ent(1, 3, 2, 5); cfg_ent(1, 4, 1, 1); cfg_n(1, 5);

        run_frame(12, 5, 1'b1, "R9 enable-late");
        run_frame(12, -1, 1'b0, "R8 split tables");

        cfg_ent(0, 0, 2, 1); cfg_n(1, 2);
        tx_rdy = 5'h0F;
        run_frame(12, -1, 1'b0, "R10 locked writes");
        tx_rdy = 5'h1F;
        run_frame(12, 3, 1'b0, "R9 disable-late");
        run_frame(12, -1, 1'b0, "R9 disabled frame");

        cfg_ent(0, 0, 64, 2); cfg_n(0, 1);
        cfg_ent(1, 0, 64, 3); cfg_ent(1, 1, 1, 7); cfg_n(1, 2);
        enable = 1'b1;
        run_frame(66, -1, 1'b0, "R3 R7 count 64");
        run_frame(10, -1, 1'b0, "R7 short frame");
        cfg_ent(0, 0, 1, 4);
        run_frame(12, -1, 1'b0, "R7 rewind R2");
        finish_run();
    end
endmodule